// File: doc/BRIEF.md
# Queue Buffer Page Allocator

This block hands out contiguous regions of a shared queue buffer memory. The buffer is split into fixed pages of 16 dwords, and a register bitmap records which pages are taken. A caller asks for a region for one queue. It gives the queue number, the region size in dwords and two 3-bit fill watermarks. The block checks the arguments, then slides a window of the requested page count over the bitmap. The window starts at page 0 and moves one page per clock. The first free fit is claimed, and the block returns the base page together with the configuration word for that queue.

A release port returns a region to the pool by queue, base page and size. It also clears the queue's claim, so the queue can be requested again. A release that names pages not currently in use, or that has malformed arguments, raises a sticky error flag. Requests and releases share one sequencer, which takes one operation at a time.

Top module: `qpa_alloc_top`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0, `rel_err` is 0, every page is free and no queue holds a region.
- R2: A request whose queue number is 32 or more completes with status 1 (bad argument), base 0 and configuration word 0. No page is claimed.
- R3: A request is rejected with status 1 if its size is not 16, 32, 64 or 128 dwords, or if either watermark has any bit set above bit 2. No page is claimed.
- R4: The claimed region is the lowest base page whose window of 1, 2, 4 or 8 pages is entirely free. The base need not be aligned to the size.
- R5: A request for which no free window fits inside the 128 pages completes with status 3 (no memory), base 0 and configuration word 0. The bitmap is unchanged.
- R6: A request for a queue that already holds a region completes with status 2 (busy), and no pages are claimed.
- R7: A successful request completes with status 0. The base page appears on `rsp_base`. `rsp_cfg` is {bit 15 = 1, bits 14:12 = full watermark, bits 11:9 = empty watermark, bits 8:7 = size code (0..3 for 16/32/64/128 dwords), bits 6:0 = base}. The pages are marked used.
- R8: `req_ready` falls in the cycle after a request is accepted. It stays low until the single-cycle `rsp_valid` pulse, which arrives within 130 cycles. The pulse coincides with `req_ready` returning to 1.
- R9: A legal release frees exactly the pages of its window and clears the queue's claim. Those pages and that queue can then be allocated again.
- R10: A release with an illegal size, a queue of 32 or more, or a window past page 127 changes nothing and sets `rel_err`. A legal release that covers any unused page also sets `rel_err`. `rel_err` stays set until reset.
- R11: When a release and a request are both valid in an idle cycle, the release is taken first. The request stays pending, with `req_ready` still 1, and is accepted in a later cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Allocation request present |
| req_ready | output | 1 | Sequencer idle; a request or release is taken this cycle |
| req_queue | input | 8 | Queue number to configure |
| req_dwords | input | 16 | Requested region size in dwords |
| req_wm_empty | input | 8 | Nearly-empty watermark (legal range 0..7) |
| req_wm_full | input | 8 | Nearly-full watermark (legal range 0..7) |
| rsp_valid | output | 1 | Single-cycle response strobe |
| rsp_status | output | 2 | 0 ok, 1 bad argument, 2 busy, 3 no memory |
| rsp_base | output | 7 | Base page of the claimed region |
| rsp_cfg | output | 16 | Configuration word for the queue |
| rel_valid | input | 1 | Release request present |
| rel_queue | input | 8 | Queue whose region is returned |
| rel_base | input | 7 | Base page of the returned region |
| rel_dwords | input | 16 | Size of the returned region in dwords |
| rel_err | output | 1 | Sticky release error flag |

## Verification
The assertions assume that callers keep request fields stable while `req_valid` is high and `req_ready` is low. They also assume that every release is issued in an idle cycle, that is, at or after the cycle where `req_ready` is 1. The bench meets both conditions. It drives all fields on the falling edge, holds a request until it sees `req_ready` high, and never starts a new operation before the previous response has been taken by the scoreboard. A bench-side page map with per-queue claim bits predicts each response and the state of the error flag.

// File: rtl/qpa_pkg.sv
package qpa_pkg;
  // Response codes; values are visible on rsp_status
  typedef enum logic [1:0] {
    ST_OK     = 2'd0,
    ST_BADARG = 2'd1,
    ST_BUSY   = 2'd2,
    ST_NOMEM  = 2'd3
  } qpa_status_e;

  // Sequencer phases
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SEARCH = 2'd1,
    PH_REPORT = 2'd2
  } qpa_phase_e;
endpackage

// File: rtl/qpa_size_decode.sv
// Maps a dword count onto a size code and a page count; flags illegal sizes.
module qpa_size_decode #(
  parameter int SIZE_W      = 16,
  parameter int PAGE_DWORDS = 16,
  parameter int NUM_SIZES   = 4,
  parameter int CODE_W      = 2,
  parameter int LEN_W       = 4
) (
  input  logic [SIZE_W-1:0] dwords,
  output logic              legal,
  output logic [CODE_W-1:0] code,
  output logic [LEN_W-1:0]  len_pages
);
  logic [NUM_SIZES-1:0] hit;

  generate
    for (genvar i = 0; i < NUM_SIZES; i++) begin : g_size
      localparam int unsigned SZ_DW = PAGE_DWORDS << i;
      assign hit[i] = (dwords == SIZE_W'(SZ_DW));
    end
  endgenerate

  always_comb begin
    legal     = |hit;
    code      = '0;
    len_pages = '0;
    for (int i = 0; i < NUM_SIZES; i++) begin
      if (hit[i]) begin
        code      = CODE_W'(i);
        len_pages = LEN_W'(1 << i);
      end
    end
  end
endmodule

// File: rtl/qpa_window.sv
// Builds the page mask covering [base, base+len) across the whole map.
module qpa_window #(
  parameter int NUM_PAGES = 128,
  parameter int BASE_W    = 7,
  parameter int LEN_W     = 4
) (
  input  logic [BASE_W-1:0]    base,
  input  logic [LEN_W-1:0]     len,
  output logic [NUM_PAGES-1:0] win
);
  localparam int SUM_W = BASE_W + LEN_W + 1;

  logic [SUM_W-1:0] lim;
  assign lim = SUM_W'(base) + SUM_W'(len);

  generate
    for (genvar p = 0; p < NUM_PAGES; p++) begin : g_page
      assign win[p] = (SUM_W'(p) >= SUM_W'(base)) && (SUM_W'(p) < lim);
    end
  endgenerate
endmodule

// File: rtl/qpa_occupancy.sv
// Used-page bitmap with one claim and one free port.
module qpa_occupancy #(
  parameter int NUM_PAGES = 128
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 claim_en,
  input  logic [NUM_PAGES-1:0] claim_mask,
  input  logic                 free_en,
  input  logic [NUM_PAGES-1:0] free_mask,
  output logic [NUM_PAGES-1:0] used_map
);
  logic [NUM_PAGES-1:0] clr_bits;
  logic [NUM_PAGES-1:0] set_bits;

  assign clr_bits = free_en  ? free_mask  : '0;
  assign set_bits = claim_en ? claim_mask : '0;

  always_ff @(posedge clk) begin
    if (rst) used_map <= '0;
    else     used_map <= (used_map & ~clr_bits) | set_bits;
  end
endmodule

// File: rtl/qpa_alloc_top.sv
module qpa_alloc_top #(
  parameter int NUM_PAGES   = 128,
  parameter int PAGE_DWORDS = 16,
  parameter int NUM_QUEUES  = 32,
  parameter int NUM_SIZES   = 4,
  parameter int QIDX_W      = 8,
  parameter int SIZE_W      = 16,
  parameter int WM_W        = 8,
  parameter int WM_BITS     = 3,
  localparam int BASE_W     = $clog2(NUM_PAGES),
  localparam int CODE_W     = $clog2(NUM_SIZES),
  localparam int CFG_W      = 1 + 2 * WM_BITS + CODE_W + BASE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [QIDX_W-1:0] req_queue,
  input  logic [SIZE_W-1:0] req_dwords,
  input  logic [WM_W-1:0]   req_wm_empty,
  input  logic [WM_W-1:0]   req_wm_full,
  output logic              rsp_valid,
  output logic [1:0]        rsp_status,
  output logic [BASE_W-1:0] rsp_base,
  output logic [CFG_W-1:0]  rsp_cfg,
  input  logic              rel_valid,
  input  logic [QIDX_W-1:0] rel_queue,
  input  logic [BASE_W-1:0] rel_base,
  input  logic [SIZE_W-1:0] rel_dwords,
  output logic              rel_err
);
  import qpa_pkg::*;

  localparam int QSEL_W  = $clog2(NUM_QUEUES);
  localparam int MAX_LEN = 1 << (NUM_SIZES - 1);
  localparam int LEN_W   = $clog2(MAX_LEN + 1);
  localparam int SUM_W   = BASE_W + LEN_W + 1;

  qpa_phase_e           phase;
  logic [NUM_PAGES-1:0] used_map;
  logic [NUM_QUEUES-1:0] qheld;

  // Latched request
  logic [QSEL_W-1:0]  lat_q;
  logic [CODE_W-1:0]  lat_code;
  logic [LEN_W-1:0]   lat_len;
  logic [WM_BITS-1:0] lat_we;
  logic [WM_BITS-1:0] lat_wf;
  qpa_status_e        lat_status;
  logic [BASE_W-1:0]  cur_base;

  // Request argument checks
  logic              rq_size_ok;
  logic [CODE_W-1:0] rq_code;
  logic [LEN_W-1:0]  rq_len;
  logic              rq_in_range;
  logic              rq_wm_ok;
  logic              rq_bad;
  logic [QSEL_W-1:0] rq_sel;

  qpa_size_decode #(
    .SIZE_W(SIZE_W), .PAGE_DWORDS(PAGE_DWORDS), .NUM_SIZES(NUM_SIZES),
    .CODE_W(CODE_W), .LEN_W(LEN_W)
  ) u_req_dec (
    .dwords(req_dwords), .legal(rq_size_ok), .code(rq_code), .len_pages(rq_len)
  );

  assign rq_in_range = (req_queue < QIDX_W'(NUM_QUEUES));
  assign rq_wm_ok    = ((req_wm_empty >> WM_BITS) == '0) &&
                       ((req_wm_full  >> WM_BITS) == '0);
  assign rq_bad      = !rq_in_range || !rq_size_ok || !rq_wm_ok;
  assign rq_sel      = req_queue[QSEL_W-1:0];

  // Search window
  logic [NUM_PAGES-1:0] srch_win;
  logic [SUM_W-1:0]     srch_end;
  logic                 srch_fits;
  logic                 srch_overlap;
  logic                 srch_found;
  logic                 srch_last;

  qpa_window #(.NUM_PAGES(NUM_PAGES), .BASE_W(BASE_W), .LEN_W(LEN_W)) u_srch_win (
    .base(cur_base), .len(lat_len), .win(srch_win)
  );

  assign srch_end     = SUM_W'(cur_base) + SUM_W'(lat_len);
  assign srch_fits    = (srch_end <= SUM_W'(NUM_PAGES));
  assign srch_overlap = |(srch_win & used_map);
  assign srch_found   = srch_fits && !srch_overlap;
  assign srch_last    = (srch_end + SUM_W'(1)) > SUM_W'(NUM_PAGES);

  // Release path
  logic                 rl_size_ok;
  logic [CODE_W-1:0]    rl_code;
  logic [LEN_W-1:0]     rl_len;
  logic [NUM_PAGES-1:0] rel_win;
  logic                 rl_fits;
  logic                 rl_legal;
  logic                 rl_stray;
  logic [QSEL_W-1:0]    rl_sel;

  qpa_size_decode #(
    .SIZE_W(SIZE_W), .PAGE_DWORDS(PAGE_DWORDS), .NUM_SIZES(NUM_SIZES),
    .CODE_W(CODE_W), .LEN_W(LEN_W)
  ) u_rel_dec (
    .dwords(rel_dwords), .legal(rl_size_ok), .code(rl_code), .len_pages(rl_len)
  );

  qpa_window #(.NUM_PAGES(NUM_PAGES), .BASE_W(BASE_W), .LEN_W(LEN_W)) u_rel_win (
    .base(rel_base), .len(rl_len), .win(rel_win)
  );

  assign rl_fits  = (SUM_W'(rel_base) + SUM_W'(rl_len)) <= SUM_W'(NUM_PAGES);
  assign rl_legal = rl_size_ok && rl_fits && (rel_queue < QIDX_W'(NUM_QUEUES));
  assign rl_stray = |(rel_win & ~used_map);
  assign rl_sel   = rel_queue[QSEL_W-1:0];

  // Handshake
  logic rel_take;
  logic accept;
  logic claim_en;
  logic free_en;

  assign req_ready = (phase == PH_IDLE);
  assign rel_take  = req_ready && rel_valid;
  assign accept    = req_ready && req_valid && !rel_valid;
  assign claim_en  = (phase == PH_SEARCH) && srch_found;
  assign free_en   = rel_take && rl_legal;

  qpa_occupancy #(.NUM_PAGES(NUM_PAGES)) u_occ (
    .clk(clk), .rst(rst),
    .claim_en(claim_en), .claim_mask(srch_win),
    .free_en(free_en), .free_mask(rel_win),
    .used_map(used_map)
  );

  // Sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_IDLE;
      qheld      <= '0;
      lat_q      <= '0;
      lat_code   <= '0;
      lat_len    <= '0;
      lat_we     <= '0;
      lat_wf     <= '0;
      lat_status <= ST_OK;
      cur_base   <= '0;
      rsp_valid  <= 1'b0;
      rsp_status <= ST_OK;
      rsp_base   <= '0;
      rsp_cfg    <= '0;
      rel_err    <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (rel_take) begin
            if (!rl_legal || rl_stray) rel_err <= 1'b1;
            if (rl_legal) qheld[rl_sel] <= 1'b0;
          end else if (accept) begin
            lat_q    <= rq_sel;
            lat_code <= rq_code;
            lat_len  <= rq_len;
            lat_we   <= req_wm_empty[WM_BITS-1:0];
            lat_wf   <= req_wm_full[WM_BITS-1:0];
            cur_base <= '0;
            if (rq_bad) begin
              lat_status <= ST_BADARG;
              phase      <= PH_REPORT;
            end else if (qheld[rq_sel]) begin
              lat_status <= ST_BUSY;
              phase      <= PH_REPORT;
            end else begin
              phase <= PH_SEARCH;
            end
          end
        end
        PH_SEARCH: begin
          if (srch_found) begin
            rsp_valid     <= 1'b1;
            rsp_status    <= ST_OK;
            rsp_base      <= cur_base;
            rsp_cfg       <= {1'b1, lat_wf, lat_we, lat_code, cur_base};
            qheld[lat_q]  <= 1'b1;
            phase         <= PH_IDLE;
          end else if (srch_last) begin
            rsp_valid  <= 1'b1;
            rsp_status <= ST_NOMEM;
            rsp_base   <= '0;
            rsp_cfg    <= '0;
            phase      <= PH_IDLE;
          end else begin
            cur_base <= cur_base + BASE_W'(1);
          end
        end
        PH_REPORT: begin
          rsp_valid  <= 1'b1;
          rsp_status <= lat_status;
          rsp_base   <= '0;
          rsp_cfg    <= '0;
          phase      <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/qpa_alloc_chk.sv
module qpa_alloc_chk #(
  parameter int NUM_PAGES  = 128,
  parameter int NUM_QUEUES = 32,
  parameter int QIDX_W     = 8,
  parameter int BASE_W     = 7,
  parameter int CODE_W     = 2,
  parameter int CFG_W      = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [QIDX_W-1:0] req_queue,
  input logic              rel_valid,
  input logic              rsp_valid,
  input logic [1:0]        rsp_status,
  input logic [BASE_W-1:0] rsp_base,
  input logic [CFG_W-1:0]  rsp_cfg,
  input logic              rel_err
);
  localparam int CNT_W = BASE_W + 2;

  logic             pend_range;
  logic [CNT_W-1:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_range <= 1'b0;
      busy_cnt   <= '0;
    end else begin
      if (req_ready && req_valid && !rel_valid)
        pend_range <= (req_queue >= QIDX_W'(NUM_QUEUES));
      if (req_ready) busy_cnt <= '0;
      else           busy_cnt <= busy_cnt + CNT_W'(1);
    end
  end

  // R2
  range_status_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && pend_range) |-> (rsp_status == 2'd1));

  // R7
  ok_fit_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_status == 2'd0) |->
      (rsp_cfg[CFG_W-1] &&
       (int'(rsp_base) + (1 << rsp_cfg[BASE_W +: CODE_W])) <= NUM_PAGES));

  // R5
  err_clean_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_status != 2'd0) |-> (rsp_cfg == '0 && rsp_base == '0));

  // R8
  rsp_idle_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> req_ready);

  // R8
  single_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R8
  accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (req_ready && req_valid && !rel_valid) |=> !req_ready);

  // R8
  latency_bound_chk: assert property (@(posedge clk) disable iff (rst)
    busy_cnt <= CNT_W'(NUM_PAGES + 2));

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    rel_err |=> rel_err);

  // R11
  rel_first_chk: assert property (@(posedge clk) disable iff (rst)
    (rel_valid && req_ready) |=> req_ready);
endmodule

bind qpa_alloc_top qpa_alloc_chk #(
  .NUM_PAGES(NUM_PAGES), .NUM_QUEUES(NUM_QUEUES), .QIDX_W(QIDX_W),
  .BASE_W(BASE_W), .CODE_W(CODE_W), .CFG_W(CFG_W)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_queue(req_queue), .rel_valid(rel_valid), .rsp_valid(rsp_valid),
  .rsp_status(rsp_status), .rsp_base(rsp_base), .rsp_cfg(rsp_cfg),
  .rel_err(rel_err)
);

// File: tb/qpa_alloc_top_tb.sv
`timescale 1ns/1ps
module qpa_alloc_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_queue = '0;
  logic [15:0] req_dwords = '0;
  logic [7:0]  req_wm_empty = '0;
  logic [7:0]  req_wm_full = '0;
  logic        rsp_valid;
  logic [1:0]  rsp_status;
  logic [6:0]  rsp_base;
  logic [15:0] rsp_cfg;
  logic        rel_valid = 1'b0;
  logic [7:0]  rel_queue = '0;
  logic [6:0]  rel_base = '0;
  logic [15:0] rel_dwords = '0;
  logic        rel_err;

  always #2 clk = ~clk;

  qpa_alloc_top u_dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_queue(req_queue),
    .req_dwords(req_dwords), .req_wm_empty(req_wm_empty), .req_wm_full(req_wm_full),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_base(rsp_base),
    .rsp_cfg(rsp_cfg), .rel_valid(rel_valid), .rel_queue(rel_queue),
    .rel_base(rel_base), .rel_dwords(rel_dwords), .rel_err(rel_err)
  );

  typedef struct {
    int    st;
    int    base;
    int    cfg;
    string tag;
  } exp_t;

  exp_t         sbq[$];
  int           checks  = 0;
  int           fails   = 0;
  int           pending = 0;
  logic [127:0] mmap    = '0;
  bit   [31:0]  mq      = '0;
  bit           merr    = 1'b0;

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int size_len(int dw);
    case (dw)
      16: return 1;
      32: return 2;
      64: return 4;
      128: return 8;
      default: return 0;
    endcase
  endfunction

  function automatic int size_code(int dw);
    case (dw)
      32: return 1;
      64: return 2;
      128: return 3;
      default: return 0;
    endcase
  endfunction

  function automatic exp_t model_req(int q, int dw, int we, int wf);
    exp_t e;
    int len;
    logic [127:0] m;
    e.st = 0; e.base = 0; e.cfg = 0; e.tag = "";
    len = size_len(dw);
    if (q >= 32 || we > 7 || wf > 7 || len == 0) e.st = 1;
    else if (mq[q]) e.st = 2;
    else begin
      e.st = 3;
      for (int b = 0; b + len <= 128; b++) begin
        m = ((128'd1 << len) - 128'd1) << b;
        if ((mmap & m) == '0) begin
          mmap  = mmap | m;
          mq[q] = 1'b1;
          e.st  = 0;
          e.base = b;
          e.cfg = (1 << 15) | (wf << 12) | (we << 9) | (size_code(dw) << 7) | b;
          break;
        end
      end
    end
    return e;
  endfunction

  function automatic void model_rel(int q, int b, int dw);
    int len;
    logic [127:0] m;
    len = size_len(dw);
    if (len == 0 || q >= 32 || b + len > 128) merr = 1'b1;
    else begin
      m = ((128'd1 << len) - 128'd1) << b;
      if ((m & ~mmap) != '0) merr = 1'b1;
      mmap  = mmap & ~m;
      mq[q] = 1'b0;
    end
  endfunction

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (sbq.size() == 0) chk("R8", "spurious response", 1, 0);
      else begin
        exp_t e;
        e = sbq.pop_front();
        chk(e.tag, "status", rsp_status, e.st);
        chk(e.tag, "base", rsp_base, e.base);
        chk(e.tag, "cfg", rsp_cfg, e.cfg);
        pending--;
      end
    end
  end

  task automatic wait_done();
    while (pending != 0) @(negedge clk);
  endtask

  task automatic do_req(int q, int dw, int we, int wf, string tag);
    exp_t e;
    e = model_req(q, dw, we, wf);
    e.tag = tag;
    sbq.push_back(e);
    pending++;
    @(negedge clk);
    req_valid = 1'b1; req_queue = q[7:0]; req_dwords = dw[15:0];
    req_wm_empty = we[7:0]; req_wm_full = wf[7:0];
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8", "ready low after accept", req_ready, 0);
    wait_done();
  endtask

  task automatic do_rel(int q, int b, int dw, string tag);
    model_rel(q, b, dw);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    rel_valid = 1'b1; rel_queue = q[7:0]; rel_base = b[6:0]; rel_dwords = dw[15:0];
    @(negedge clk);
    rel_valid = 1'b0;
    chk(tag, "rel_err", rel_err, merr);
    chk(tag, "ready after release", req_ready, 1);
  endtask

  // R11: release and request offered in the same idle cycle
  task automatic do_both(int rq, int rb, int rdw, int q, int dw, string tag);
    exp_t e;
    model_rel(rq, rb, rdw);
    e = model_req(q, dw, 0, 0);
    e.tag = tag;
    sbq.push_back(e);
    pending++;
    @(negedge clk);
    rel_valid = 1'b1; rel_queue = rq[7:0]; rel_base = rb[6:0]; rel_dwords = rdw[15:0];
    req_valid = 1'b1; req_queue = q[7:0]; req_dwords = dw[15:0];
    req_wm_empty = '0; req_wm_full = '0;
    @(negedge clk);
    rel_valid = 1'b0;
    chk(tag, "request held while release taken", req_ready, 1);
    chk(tag, "rel_err", rel_err, merr);
    @(negedge clk);
    req_valid = 1'b0;
    chk(tag, "request taken after release", req_ready, 0);
    wait_done();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R8: watchdog expired actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "ready", req_ready, 1);
    chk("R1", "rsp_valid", rsp_valid, 0);
    chk("R1", "rel_err", rel_err, 0);

    do_req(0, 16, 1, 2, "R1");     // empty map: base 0
    do_req(1, 32, 0, 0, "R4");     // unaligned base 1
    do_req(2, 64, 7, 7, "R7");     // base 3, full watermarks
    do_req(0, 16, 0, 0, "R6");     // queue 0 already holds a region
    do_req(40, 16, 0, 0, "R2");
    do_req(32, 16, 0, 0, "R2");    // first out-of-range index
    do_req(5, 48, 0, 0, "R3");
    do_req(5, 0, 0, 0, "R3");
    do_req(5, 16, 8, 0, "R3");
    do_req(5, 16, 0, 9, "R3");

    do_rel(1, 1, 32, "R9");
    do_req(3, 16, 0, 0, "R9");     // reuses freed page 1
    do_req(4, 32, 0, 0, "R4");     // hole at page 2 too small, base 7
    do_req(1, 16, 0, 0, "R9");     // queue 1 claim cleared, page 2

    for (int q = 5; q < 20; q++) do_req(q, 128, 3, 4, "R5");
    do_req(20, 16, 0, 0, "R4");    // tail page 121
    do_req(21, 128, 0, 0, "R5");

    do_rel(0, 0, 16, "R9");
    do_rel(0, 0, 16, "R10");       // page 0 already free
    do_rel(3, 1, 48, "R10");       // illegal size, no change
    do_req(3, 16, 0, 0, "R10");    // still held: busy
    do_req(0, 16, 0, 0, "R9");     // page 0 again

    do_both(20, 121, 16, 22, 32, "R11");

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule